// File: doc/BRIEF.md
# Gated-Entry Serial-to-Parallel Shift Register

This block is a chain of storage stages with one serial entry point and a parallel view of every stage. On each rising clock edge, every stage takes the value of its neighbour nearer the entry end. The first stage takes the logical AND of two data pins. Because of this AND, either pin can serve as an active-high gate for the other. Tie one pin high and the other carries the data. Tie both pins together and they form a single serial input.

An active-low clear acts without a clock and overrides everything else, driving every stage to zero. The last stage also drives a serial output, so several of these registers can be chained end to end. The stage count is a parameter and defaults to eight.

Top module: `gated_sipo`

## Requirements
- R1: While `rst_n` is low, every bit of `q` and `sout` reads 0. The clear takes effect as soon as `rst_n` falls, without waiting for a clock edge.
- R2: On each rising edge of `clk` with `rst_n` high, bit `q[i]` takes the value `q[i-1]` held before the edge, for i = 1 to STAGES-1. Bit 0 is the entry end and bit STAGES-1 is the far end.
- R3: On each rising edge with `rst_n` high, `q[0]` takes `din_a & din_b` as sampled at that edge.
- R4: When `din_b` is held at 1, the sequence clocked in equals the `din_a` sequence, and the reverse holds as well. When either pin is held at 0, only zeros enter.
- R5: `sout` always equals `q[STAGES-1]`.
- R6: With `rst_n` high, `q` does not change between rising edges, even when `din_a` or `din_b` toggles.
- R7: The first rising edge after `rst_n` returns high loads `din_a & din_b` into `q[0]` and zeros into every other stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous clear, active low |
| din_a | input | 1 | Serial data pin, ANDed with `din_b` |
| din_b | input | 1 | Serial data pin, ANDed with `din_a` |
| q | output | STAGES | Parallel view of all stages, bit 0 at the entry end |
| sout | output | 1 | Far-end stage, for cascading |

## Verification
Two functions can fall in the same cycle: the asynchronous clear and the synchronous shift. The bench pulls `rst_n` low halfway between two clock edges. It checks right away that `q` is zero, before any edge arrives. It then holds the clear across a rising edge while the data pins toggle, to confirm that the clear wins over the shift. Last, it releases the clear between edges and judges the first shift afterward against a model that starts from all zeros.

// File: rtl/gated_sipo.sv
module gated_sipo #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_a,
  input  logic              din_b,
  output logic [STAGES-1:0] q,
  output logic              sout
);

  logic entry;

  assign entry = din_a & din_b;
  assign sout  = q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[STAGES-2:0], entry};
  end

  // R1: the clear dominates at every edge it covers
  a_r1_clear: assert property (@(posedge clk) !rst_n |-> (q == '0));

  // R2: stages advance one place toward the far end
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q[STAGES-1:1] == $past(q[STAGES-2:0])));

  // R3: entry stage captures the AND of both data pins
  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (q[0] == $past(din_a & din_b)));

  // R7: first shift after release starts from an empty register
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (q[STAGES-1:1] == '0));

endmodule

// File: tb/gated_sipo_test.sv
`timescale 1ns/100ps
module gated_sipo_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din_a = 1'b0;
  logic din_b = 1'b0;
  logic [N-1:0] q;
  logic sout;

  logic [N-1:0] exp_q = '0;
  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  gated_sipo #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .din_a(din_a), .din_b(din_b), .q(q), .sout(sout)
  );

  always #2 clk = ~clk;

  function automatic logic [N-1:0] next_state(logic [N-1:0] cur, logic a, logic b);
    return {cur[N-2:0], a & b};
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic a, logic b, string req);
    @(negedge clk);
    din_a = a;
    din_b = b;
    @(posedge clk);
    exp_q = next_state(exp_q, a, b);
    #1;
    chk(req, q, exp_q);
    chk("R5", {{(N-1){1'b0}}, sout}, {{(N-1){1'b0}}, exp_q[N-1]});
  endtask

  task automatic mid_clear(logic a, logic b);
    @(negedge clk);
    #0.5;
    rst_n = 1'b0;
    exp_q = '0;
    #0.5;
    chk("R1 immediate", q, '0);
    din_a = ~din_a;
    din_b = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 held over edge", q, '0);
    @(negedge clk);
    #0.5;
    rst_n = 1'b1;
    din_a = a;
    din_b = b;
    @(posedge clk);
    exp_q = next_state(exp_q, a, b);
    #1;
    chk("R7 first shift", q, exp_q);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      runs++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk("R1 reset state", q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2/R3: walk a one through all stages
    step(1'b1, 1'b1, "R3 entry one");
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, "R2 walking");
    // R4: gating in both directions
    step(1'b1, 1'b1, "R4 b enables a");
    step(1'b0, 1'b1, "R4 b enables a");
    step(1'b1, 1'b1, "R4 b enables a");
    step(1'b1, 1'b0, "R4 a enables b");
    step(1'b1, 1'b1, "R4 a enables b");
    step(1'b1, 1'b0, "R4 b gates off");
    step(1'b0, 1'b1, "R4 a gates off");
    for (int i = 0; i < N; i++) step(1'b1, 1'b1, "R2 fill ones");
    // R6: toggling between edges has no effect
    @(negedge clk);
    din_a = 1'b0; #0.5; din_a = 1'b1; din_b = 1'b0; #0.5;
    chk("R6 stable between edges", q, exp_q);
    // mid-cycle clears against the shift
    mid_clear(1'b1, 1'b1);
    mid_clear(1'b0, 1'b1);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 39) == 0) mid_clear(1'($urandom), 1'($urandom));
      else step(1'($urandom), 1'($urandom), "R2 R3 random");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule